// File: doc/BRIEF.md
# Float to Integer Truncating Converter

This block turns an unpacked floating-point operand into a 32-bit two's-complement integer. The operand arrives as separate fields: a sign, a class code, a signed unbiased exponent, a 66-bit mantissa and a sticky bit. The mantissa holds an explicit leading one followed by fraction bits and two guard/round bits. The conversion always truncates toward zero. A rounding-mode input is present so that the block can sit beside a shared mode bus, but it has no effect on the result.

The result and two status flags are registered. They appear one cycle after an input strobe, together with a one-cycle valid pulse. The inexact flag reports that nonzero bits were thrown away. The operand-error flag reports that the operand could not be represented as an integer: it was out of range, infinite or not a number. In that case the output saturates toward the operand's sign and the inexact indication is withdrawn. Underflow is never reported.

Top module: `f2i_trunc`

## Requirements
- R1: A class code of 0 (zero) produces integer 0 with both flags low, whatever the sign, exponent and mantissa.
- R2: Class codes 2 (infinity), 3 (quiet NaN) and 4 (signalling NaN), and the unused codes 5 to 7, are treated as overflow.
- R3: A number (class code 1) whose signed exponent is 32 or greater is treated as overflow.
- R4: Mantissa bit 65 carries weight 2^exponent, and each lower bit carries half the weight of the bit above it. A number that is in range yields its integer part truncated toward zero: the magnitude is never incremented, and the result is two's-complement negated when the sign is 1.
- R5: For an in-range number, inexact is 1 exactly when any bit below the integer part is 1, or the sticky input is 1. Bits 1:0 are counted among these bits, and a negative exponent yields 0. Operand error is then 0.
- R6: A magnitude of 2^31 or more overflows for a positive sign. For a negative sign, only a magnitude greater than 2^31 overflows, so -2^31 is accepted.
- R7: On any overflow, the output is 0x7FFFFFFF for sign 0 and 0x80000000 for sign 1, operand error is 1 and inexact is 0.
- R8: The 2-bit rounding-mode input has no effect on any output.
- R9: `out_valid` is high for exactly the one cycle after each cycle with `in_valid` high. The result and flag outputs keep their values while no new input is strobed.
- R10: While reset is asserted, and after it, until the first strobe is taken, `out_valid`, `out_int`, `out_inexact` and `out_operr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe: the operand fields are valid this cycle |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_class | input | 3 | 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_exp | input | 16 | Signed unbiased exponent |
| in_mant | input | 66 | Leading one at bit 65, guard/round at bits 1:0 |
| in_sticky | input | 1 | OR of all bits below the mantissa |
| in_rnd_mode | input | 2 | Rounding mode; ignored |
| out_valid | output | 1 | One-cycle pulse, result valid |
| out_int | output | 32 | Converted integer |
| out_inexact | output | 1 | Discarded bits were nonzero |
| out_operr | output | 1 | Overflow or non-number operand |

## Verification
Most faults in this block are faults in a value inside the cycle rather than in stored state. A wrong shift amount or a wrong lost-bit mask shows up as a wrong integer or a wrong inexact flag on the very next valid pulse. An off-by-one in the range compare only shows at the exact boundary magnitudes of plus and minus 2^31, so those values are driven by directed tests. The only real state is the output register, and a fault there shows as a stray or missing valid pulse, or as outputs that move while no strobe is taken. Both are visible one cycle after the strobe.

// File: rtl/f2i_pkg.sv
// Package: shared class codes and sizing defaults for the float-to-integer
// truncating converter. Assumes a 3-bit class field on the operand.
package f2i_pkg;
    localparam int unsigned CLASS_W   = 3;
    localparam logic [CLASS_W-1:0] CLS_ZERO = 3'd0;
    localparam logic [CLASS_W-1:0] CLS_NUM  = 3'd1;
    localparam logic [CLASS_W-1:0] CLS_INF  = 3'd2;
    localparam logic [CLASS_W-1:0] CLS_QNAN = 3'd3;
    localparam logic [CLASS_W-1:0] CLS_SNAN = 3'd4;

    localparam int unsigned DEF_MANT_W = 66;
    localparam int unsigned DEF_EXP_W  = 16;
    localparam int unsigned DEF_INT_W  = 32;
endpackage

// File: rtl/f2i_align.sv
// Module: f2i_align
// Moves the integer part of the mantissa into the low INT_W bits and
// collects every discarded bit, plus the sticky input, into one lost flag.
// Assumes the caller ignores mag when the exponent is INT_W or more, and a
// negative exponent yields mag = 0.
module f2i_align #(
    parameter int unsigned MANT_W = 66,
    parameter int unsigned EXP_W  = 16,
    parameter int unsigned INT_W  = 32
) (
    input  logic [MANT_W-1:0] mant,
    input  logic              sticky,
    input  logic [EXP_W-1:0]  exp,
    output logic [INT_W-1:0]  mag,
    output logic              lost
);
    localparam int unsigned LEAD  = MANT_W - 1;
    localparam int unsigned SH_W  = $clog2(MANT_W + 1);
    localparam int unsigned IDX_W = $clog2(INT_W);

    logic              exp_neg;
    logic [IDX_W-1:0]  exp_lo;
    logic [SH_W-1:0]   shamt;
    logic [MANT_W-1:0] drop_mask;
    logic [MANT_W-1:0] shifted;

    // Purpose: derive the right-shift distance from the low exponent bits.
    always_comb begin
        exp_neg = exp[EXP_W-1];
        exp_lo  = exp[IDX_W-1:0];
        shamt   = SH_W'(LEAD) - SH_W'(exp_lo);
    end

    // One mask bit per mantissa position: set when that bit falls below the
    // integer part.
    for (genvar i = 0; i < MANT_W; i++) begin : g_mask
        always_comb drop_mask[i] = exp_neg || (SH_W'(i) < shamt);
    end

    // Purpose: form the integer magnitude and the lost-bit summary.
    always_comb begin
        shifted = mant >> shamt;
        mag     = exp_neg ? '0 : shifted[INT_W-1:0];
        lost    = sticky | (|(mant & drop_mask));
    end
endmodule

// File: rtl/f2i_limit.sv
// Module: f2i_limit
// Decides whether the operand cannot be represented in INT_W signed bits.
// Assumes mag is only meaningful for an in-range number.
module f2i_limit
    import f2i_pkg::*;
#(
    parameter int unsigned EXP_W = 16,
    parameter int unsigned INT_W = 32
) (
    input  logic [CLASS_W-1:0] cls,
    input  logic               sign,
    input  logic [EXP_W-1:0]   exp,
    input  logic [INT_W-1:0]   mag,
    output logic               ovf
);
    localparam logic [INT_W:0] HALF = (INT_W+1)'(1) << (INT_W - 1);

    logic           not_number;
    logic           exp_big;
    logic [INT_W:0] limit;
    logic           mag_big;

    // Purpose: non-number classes and large exponents always overflow.
    always_comb begin
        not_number = (cls != CLS_NUM) && (cls != CLS_ZERO);
        exp_big    = $signed(exp) >= $signed(EXP_W'(INT_W));
    end

    // Purpose: a negative operand may reach one more magnitude step.
    always_comb begin
        limit   = HALF + (INT_W+1)'(sign);
        mag_big = {1'b0, mag} >= limit;
    end

    // Purpose: combine the three overflow sources.
    always_comb begin
        ovf = not_number || ((cls == CLS_NUM) && (exp_big || mag_big));
    end
endmodule

// File: rtl/f2i_result.sv
// Module: f2i_result
// Chooses between zero, the saturated value and the signed magnitude, and
// sets the flags. Assumes ovf has already taken the class into account.
module f2i_result
    import f2i_pkg::*;
#(
    parameter int unsigned INT_W = 32
) (
    input  logic [CLASS_W-1:0] cls,
    input  logic               sign,
    input  logic [INT_W-1:0]   mag,
    input  logic               lost,
    input  logic               ovf,
    output logic [INT_W-1:0]   value,
    output logic               inexact,
    output logic               operr
);
    localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};

    logic [INT_W-1:0] sat_val;
    logic [INT_W-1:0] signed_val;

    // Purpose: build both candidate results.
    always_comb begin
        sat_val    = POS_MAX + INT_W'(sign);
        signed_val = sign ? (~mag + INT_W'(1)) : mag;
    end

    // Purpose: select the result and flags by operand case.
    always_comb begin
        if (cls == CLS_ZERO) begin
            value   = '0;
            inexact = 1'b0;
            operr   = 1'b0;
        end else if (ovf) begin
            value   = sat_val;
            inexact = 1'b0;
            operr   = 1'b1;
        end else begin
            value   = signed_val;
            inexact = lost;
            operr   = 1'b0;
        end
    end
endmodule

// File: rtl/f2i_trunc.sv
// Module: f2i_trunc (top)
// Truncating float-to-integer conversion with a registered output stage.
// Assumes in_mant holds an explicit leading one at its top bit for class
// "number"; the rounding mode input is deliberately unused.
module f2i_trunc
    import f2i_pkg::*;
#(
    parameter int unsigned MANT_W = DEF_MANT_W,
    parameter int unsigned EXP_W  = DEF_EXP_W,
    parameter int unsigned INT_W  = DEF_INT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sign,
    input  logic [2:0]         in_class,
    input  logic [EXP_W-1:0]   in_exp,
    input  logic [MANT_W-1:0]  in_mant,
    input  logic               in_sticky,
    input  logic [1:0]         in_rnd_mode,
    output logic               out_valid,
    output logic [INT_W-1:0]   out_int,
    output logic               out_inexact,
    output logic               out_operr
);
    logic [INT_W-1:0] mag;
    logic             lost;
    logic             ovf;
    logic [INT_W-1:0] value;
    logic             inexact;
    logic             operr;
    logic             mode_unused;

    // Purpose: the rounding mode is accepted but never used.
    always_comb mode_unused = ^in_rnd_mode;

    f2i_align #(.MANT_W(MANT_W), .EXP_W(EXP_W), .INT_W(INT_W)) align_i (
        .mant   (in_mant),
        .sticky (in_sticky),
        .exp    (in_exp),
        .mag    (mag),
        .lost   (lost)
    );

    f2i_limit #(.EXP_W(EXP_W), .INT_W(INT_W)) limit_i (
        .cls  (in_class),
        .sign (in_sign),
        .exp  (in_exp),
        .mag  (mag),
        .ovf  (ovf)
    );

    f2i_result #(.INT_W(INT_W)) result_i (
        .cls     (in_class),
        .sign    (in_sign),
        .mag     (mag),
        .lost    (lost),
        .ovf     (ovf),
        .value   (value),
        .inexact (inexact),
        .operr   (operr)
    );

    // Purpose: one-cycle valid pulse following each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Purpose: capture the result on a strobe, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_int     <= '0;
            out_inexact <= 1'b0;
            out_operr   <= 1'b0;
        end else if (in_valid) begin
            out_int     <= value;
            out_inexact <= inexact;
            out_operr   <= operr;
        end
    end
endmodule

// File: rtl/f2i_trunc_chk.sv
// Checker for f2i_trunc: relates the strobed operand to the registered
// result one cycle later. Attached by the bind at the end of this file.
module f2i_trunc_chk
    import f2i_pkg::*;
#(
    parameter int unsigned MANT_W = DEF_MANT_W,
    parameter int unsigned EXP_W  = DEF_EXP_W,
    parameter int unsigned INT_W  = DEF_INT_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_sign,
    input logic [2:0]         in_class,
    input logic [EXP_W-1:0]   in_exp,
    input logic [MANT_W-1:0]  in_mant,
    input logic               in_sticky,
    input logic [1:0]         in_rnd_mode,
    input logic               out_valid,
    input logic [INT_W-1:0]   out_int,
    input logic               out_inexact,
    input logic               out_operr
);
    localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] NEG_MIN = {1'b1, {(INT_W-1){1'b0}}};

    logic rst_q;

    // Purpose: remember that the previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_q <= 1'b0;
        else        rst_q <= 1'b1;
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |-> (out_valid == $past(in_valid)));                        // R9

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_q && !$past(in_valid)) |-> ($stable(out_int) && $stable(out_operr)
                                         && $stable(out_inexact)));       // R9

    AST_ZERO_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_q && $past(in_valid) && $past(in_class) == CLS_ZERO)
        |-> (out_int == '0 && !out_inexact && !out_operr));               // R1

    AST_NON_NUMBER: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_q && $past(in_valid) && $past(in_class) != CLS_ZERO
         && $past(in_class) != CLS_NUM) |-> out_operr);                   // R2

    AST_BIG_EXP: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_q && $past(in_valid) && $past(in_class) == CLS_NUM
         && $signed($past(in_exp)) >= $signed(EXP_W'(INT_W))) |-> out_operr); // R3

    AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_operr) |-> (!out_inexact
            && (out_int == POS_MAX || out_int == NEG_MIN)));              // R7

    AST_NEG_EXP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_q && $past(in_valid) && $past(in_class) == CLS_NUM
         && $past(in_exp[EXP_W-1])) |-> (out_int == '0 && !out_operr));  // R5
endmodule

bind f2i_trunc f2i_trunc_chk #(.MANT_W(MANT_W), .EXP_W(EXP_W), .INT_W(INT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_sign     (in_sign),
    .in_class    (in_class),
    .in_exp      (in_exp),
    .in_mant     (in_mant),
    .in_sticky   (in_sticky),
    .in_rnd_mode (in_rnd_mode),
    .out_valid   (out_valid),
    .out_int     (out_int),
    .out_inexact (out_inexact),
    .out_operr   (out_operr)
);

// File: tb/f2i_trunc_tb_top.sv
module f2i_trunc_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sign = 1'b0;
    logic [2:0]  in_class = 3'd0;
    logic [15:0] in_exp = 16'd0;
    logic [65:0] in_mant = 66'd0;
    logic        in_sticky = 1'b0;
    logic [1:0]  in_rnd_mode = 2'd0;
    logic        out_valid;
    logic [31:0] out_int;
    logic        out_inexact;
    logic        out_operr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [65:0] ONE = 66'h2_0000_0000_0000_0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    f2i_trunc dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
        .in_class(in_class), .in_exp(in_exp), .in_mant(in_mant),
        .in_sticky(in_sticky), .in_rnd_mode(in_rnd_mode),
        .out_valid(out_valid), .out_int(out_int),
        .out_inexact(out_inexact), .out_operr(out_operr)
    );

    // Expected {int, inexact, operr} from the requirements.
    function automatic logic [33:0] ref_conv(input logic s, input logic [2:0] c,
                                             input logic [15:0] e,
                                             input logic [65:0] m, input logic st);
        longint ev;
        logic [63:0] mag;
        logic lost;
        logic [31:0] sat;
        sat = s ? 32'h8000_0000 : 32'h7FFF_FFFF;
        ev = longint'($signed(e));
        if (c == 3'd0) return 34'd0;                           // R1
        if (c != 3'd1) return {sat, 1'b0, 1'b1};               // R2
        if (ev >= 32) return {sat, 1'b0, 1'b1};                // R3
        mag = 64'd0;
        lost = st;
        for (int i = 0; i < 66; i++) begin
            longint pos;
            pos = longint'(i) - (65 - ev);
            if (pos >= 0) mag[pos] = m[i];
            else if (m[i]) lost = 1'b1;
        end
        if (mag >= 64'h8000_0000 + 64'(s)) return {sat, 1'b0, 1'b1}; // R6
        return {(s ? (32'd0 - mag[31:0]) : mag[31:0]), lost, 1'b0};  // R4 R5
    endfunction

    task automatic check(input string tag, input logic [33:0] got, input logic [33:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got int=%h inx=%b oper=%b expected int=%h inx=%b oper=%b",
                     tag, got[33:2], got[1], got[0], exp[33:2], exp[1], exp[0]);
        end
    endtask

    // Strobe one operand, check the pulse result, then check the idle hold.
    task automatic apply(input string tag, input logic s, input logic [2:0] c,
                         input logic [15:0] e, input logic [65:0] m,
                         input logic st, input logic [1:0] mode);
        logic [33:0] exp_v;
        logic [33:0] got;
        @(negedge clk);
        in_valid = 1'b1; in_sign = s; in_class = c; in_exp = e;
        in_mant = m; in_sticky = st; in_rnd_mode = mode;
        exp_v = ref_conv(s, c, e, m, st);
        @(negedge clk);
        in_valid = 1'b0;
        in_mant = ~m; in_exp = 16'h0005; in_class = 3'd1; in_rnd_mode = ~mode;
        got = {out_int, out_inexact, out_operr};
        check(tag, got, exp_v);
        checks++;
        if (out_valid !== 1'b1) begin
            errors++;
            $display("FAIL R9 valid pulse: got %b expected 1", out_valid);
        end
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || {out_int, out_inexact, out_operr} !== got) begin
            errors++;
            $display("FAIL R9 hold: got valid=%b val=%h expected valid=0 val=%h",
                     out_valid, {out_int, out_inexact, out_operr}, got);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R9: got no completion expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        checks++;                                                 // R10
        if ({out_valid, out_int, out_inexact, out_operr} !== 35'd0) begin
            errors++;
            $display("FAIL R10 reset: got %h expected 0",
                     {out_valid, out_int, out_inexact, out_operr});
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if ({out_valid, out_int, out_inexact, out_operr} !== 35'd0) begin
            errors++;
            $display("FAIL R10 after reset: got %h expected 0",
                     {out_valid, out_int, out_inexact, out_operr});
        end

        apply("R1 zero pos",    1'b0, 3'd0, 16'd40, ONE | 66'd3, 1'b1, 2'd0);
        apply("R1 zero neg",    1'b1, 3'd0, 16'hFFF0, ONE, 1'b0, 2'd2);
        apply("R2 inf",         1'b0, 3'd2, 16'd0, ONE, 1'b0, 2'd0);
        apply("R2 qnan neg",    1'b1, 3'd3, 16'd0, ONE, 1'b1, 2'd1);
        apply("R2 snan",        1'b0, 3'd4, 16'd3, ONE, 1'b0, 2'd0);
        apply("R2 reserved",    1'b1, 3'd6, 16'd3, ONE, 1'b0, 2'd0);
        apply("R3 exp 32",      1'b0, 3'd1, 16'd32, ONE, 1'b0, 2'd0);
        apply("R3 exp huge neg",1'b1, 3'd1, 16'h7FFF, ONE, 1'b1, 2'd3);
        apply("R4 one exact",   1'b0, 3'd1, 16'd0, ONE, 1'b0, 2'd0);
        apply("R4 2.75 trunc",  1'b0, 3'd1, 16'd1, ONE | (ONE >> 2) | (ONE >> 3), 1'b0, 2'd0);
        apply("R4 -2.75 trunc", 1'b1, 3'd1, 16'd1, ONE | (ONE >> 2) | (ONE >> 3), 1'b0, 2'd3);
        apply("R5 guard only",  1'b0, 3'd1, 16'd31, ONE | 66'd2, 1'b0, 2'd0);
        apply("R5 sticky only", 1'b1, 3'd1, 16'd5, ONE, 1'b1, 2'd0);
        apply("R5 exp -1",      1'b0, 3'd1, 16'hFFFF, ONE, 1'b0, 2'd0);
        apply("R5 exp min",     1'b1, 3'd1, 16'h8000, ONE, 1'b0, 2'd0);
        apply("R6 -2^31",       1'b1, 3'd1, 16'd31, ONE, 1'b0, 2'd0);
        apply("R6 +2^31",       1'b0, 3'd1, 16'd31, ONE, 1'b0, 2'd0);
        apply("R6 -2^31 frac",  1'b1, 3'd1, 16'd31, ONE | 66'd1, 1'b0, 2'd0);
        apply("R6 -(2^31+1)",   1'b1, 3'd1, 16'd31, ONE | (ONE >> 31), 1'b0, 2'd0);
        apply("R7 max pos",     1'b0, 3'd1, 16'd30, {66{1'b1}}, 1'b1, 2'd0);

        // R8: the same operands under every rounding mode.
        for (int k = 0; k < 4; k++) begin
            apply("R8 mode neg",  1'b1, 3'd1, 16'd3, ONE | (ONE >> 4) | 66'd1, 1'b1, 2'(k));
            apply("R8 mode half", 1'b0, 3'd1, 16'd2, ONE | (ONE >> 3), 1'b0, 2'(k));
        end

        // Random mix; R4 R5 R6 R7 against the reference function.
        for (int n = 0; n < 600; n++) begin
            logic [65:0] m;
            logic [15:0] e;
            logic [2:0]  c;
            logic        st;
            int          r;
            r = int'($urandom % 16);
            c = (r == 0) ? 3'd0 : (r == 1) ? 3'($urandom % 8) : 3'd1;
            e = 16'($signed(int'($urandom % 44) - 6));
            if ($urandom % 20 == 0) e = 16'($urandom);
            m = {1'b1, 33'($urandom), 32'($urandom)};
            st = 1'($urandom);
            if ($urandom % 4 == 0 && $signed(e) >= 0 && $signed(e) < 32) begin
                m = (m >> (65 - int'(e))) << (65 - int'(e));
                st = 1'b0;
            end
            apply("R4 random", 1'($urandom), c, e, m, st, 2'($urandom));
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule